// File: doc/BRIEF.md
# Password Memory Security Lock

This block guards a protected memory region with a 128-bit password. The password sits in eight consecutive 16-bit words inside that region. A CPU-side register port holds eight key registers and a control/status word. The block watches reads of the password words as they pass on the memory port, and it drives an `unlocked` flag. That flag decides whether data accesses into the protected region may go through.

The block comes out of reset locked. Two things unlock it: a dummy read of every password word, and key writes equal to the stored words. They may happen in either order. If the password words all read as ones (an erased part), the dummy reads alone unlock it. A password of all zeros can never be unlocked.

While locked, code running outside the region cannot read or write data inside it. Instruction fetches into the region still pass. Software can relock the block at any time through a control bit. After a relock, a fresh set of dummy reads is needed before the block unlocks again.

Top module: `pwlock`

## Requirements
- R1: After reset the block is locked: `unlocked` is 0, and reading register address 8 returns 1 in bit 0.
- R2: Write the eight keys matching the password first (register addresses 0..7 hold key words 0..7), then dummy-read all eight password words (`PW_BASE`..`PW_BASE+7`). `unlocked` then rises on the second clock edge after the last read.
- R3: In the other order, dummy reads first and matching keys last, `unlocked` rises on the second clock edge after the last key write.
- R4: If any one password word has not been dummy-read since reset or since the last relock, the block stays locked even when the keys match.
- R5: A key that differs from the password in any word keeps the block locked.
- R6: When all eight password words read 0xFFFF, dummy reads of all eight unlock the block whatever the keys hold.
- R7: When all eight password words read 0x0000, the block never unlocks, even with all keys written to 0x0000.
- R8: Writing 1 to bit 0 of register address 8 relocks an unlocked block on the next edge. It also forgets all earlier dummy reads, so matching keys alone do not unlock it again.
- R9: While locked, a data read of the secure region (`SEC_BASE`..`SEC_BASE+SEC_WORDS-1`) by code outside it (`pc_secure`=0) returns zero on `mem_rdata`. A data write there is dropped (`mem_we_out`=0).
- R10: The following always pass, so `mem_rdata` equals `mem_rdata_in` and writes reach `mem_we_out`: instruction fetches (`mem_fetch`=1), accesses made by code in the secure region (`pc_secure`=1), and accesses to addresses outside the region.
- R11: Once the block is unlocked, data reads and writes into the secure region from code outside it pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address: 0..7 keys, 8 control/status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (bit 0 = locked at address 8) |
| mem_req | input | 1 | Memory access request |
| mem_we | input | 1 | Access is a write |
| mem_fetch | input | 1 | Access is an instruction fetch |
| pc_secure | input | 1 | Requesting code executes inside the secure region |
| mem_addr | input | AW | Access address |
| mem_rdata_in | input | 16 | Read data from the memory array |
| mem_rdata | output | 16 | Filtered read data to the requester |
| mem_we_out | output | 1 | Filtered write enable to the memory array |
| unlocked | output | 1 | Block is unlocked |

## Verification
The filtering of `mem_rdata` and `mem_we_out` is combinational. The bench therefore applies an access on the falling edge and checks the filtered result one time step later, within the same cycle. A password read is captured on the next rising edge, and the lock flag moves on the rising edge after that. So every unlock check samples just after the second rising edge that follows the last read or key write. The relock result is checked just after the first edge that follows the control write.

// File: rtl/pwlock.sv
module pwlock #(
  parameter int AW        = 16,
  parameter int SEC_BASE  = 'h8000,
  parameter int SEC_WORDS = 'h4000,
  parameter int PW_BASE   = 'hBFF8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [3:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          mem_req,
  input  logic          mem_we,
  input  logic          mem_fetch,
  input  logic          pc_secure,
  input  logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata_in,
  output logic [15:0]   mem_rdata,
  output logic          mem_we_out,
  output logic          unlocked
);
  localparam int PW_WORDS = 8;
  localparam int SEC_END  = SEC_BASE + SEC_WORDS;
  localparam int PW_END   = PW_BASE + PW_WORDS;
  localparam logic [3:0] CTRL_ADDR = 4'd8;

  logic [15:0] key_q [PW_WORDS];
  logic [15:0] shd_q [PW_WORDS];
  logic [PW_WORDS-1:0] seen_q;
  logic unlocked_q;

  logic [AW:0] addr_x;
  assign addr_x = {1'b0, mem_addr};

  logic in_sec, pw_hit, snoop, force_wr, allow;
  logic [2:0] pw_idx;
  logic [AW:0] pw_off;
  assign in_sec   = (addr_x >= (AW+1)'(SEC_BASE)) && (addr_x < (AW+1)'(SEC_END));
  assign pw_hit   = (addr_x >= (AW+1)'(PW_BASE)) && (addr_x < (AW+1)'(PW_END));
  assign pw_off   = addr_x - (AW+1)'(PW_BASE);
  assign pw_idx   = pw_off[2:0];
  assign snoop    = mem_req && !mem_we && !mem_fetch && pw_hit;
  assign force_wr = reg_wr && (reg_addr == CTRL_ADDR) && reg_wdata[0];

  logic all_ones, all_zero, key_eq, unlock_ok;
  always_comb begin
    all_ones = 1'b1;
    all_zero = 1'b1;
    key_eq   = 1'b1;
    for (int i = 0; i < PW_WORDS; i++) begin
      all_ones = all_ones && (shd_q[i] == 16'hFFFF);
      all_zero = all_zero && (shd_q[i] == 16'h0000);
      key_eq   = key_eq && (shd_q[i] == key_q[i]);
    end
  end
  assign unlock_ok = (&seen_q) && !all_zero && (all_ones || key_eq);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PW_WORDS; i++) begin
        key_q[i] <= '0;
        shd_q[i] <= '0;
      end
      seen_q     <= '0;
      unlocked_q <= 1'b0;
    end else begin
      if (reg_wr && !reg_addr[3]) key_q[reg_addr[2:0]] <= reg_wdata;
      if (force_wr) begin
        seen_q     <= '0;
        unlocked_q <= 1'b0;
      end else begin
        if (snoop) begin
          shd_q[pw_idx]  <= mem_rdata_in;
          seen_q[pw_idx] <= 1'b1;
        end
        if (!unlocked_q) unlocked_q <= unlock_ok;
      end
    end
  end

  assign allow      = mem_fetch || pc_secure || unlocked_q || !in_sec;
  assign mem_rdata  = allow ? mem_rdata_in : 16'h0000;
  assign mem_we_out = mem_req && mem_we && allow;
  assign unlocked   = unlocked_q;
  assign reg_rdata  = (reg_addr == CTRL_ADDR) ? {15'b0, !unlocked_q} : 16'h0000;

  assert_zero_pw_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((&seen_q) && all_zero && !unlocked_q) |=> !unlocked_q);

  assert_rise_needs_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked_q) |-> $past(&seen_q));

  assert_force_relock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    force_wr |=> (!unlocked_q && seen_q == '0));

  assert_block_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && in_sec && !pc_secure && !mem_fetch && !unlocked_q) |-> !mem_we_out);

  assert_block_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sec && !pc_secure && !mem_fetch && !unlocked_q) |-> (mem_rdata == 16'h0000));

  assert_fetch_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fetch |-> (mem_rdata == mem_rdata_in));
endmodule

// File: tb/test_pwlock.sv
module test_pwlock;
  localparam int AW = 16;
  localparam logic [15:0] PWB = 16'hBFF8;
  localparam logic [15:0] SECA = 16'h9000;
  localparam logic [15:0] OUTA = 16'h2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic mem_req = 1'b0, mem_we = 1'b0, mem_fetch = 1'b0, pc_secure = 1'b0;
  logic [AW-1:0] mem_addr = '0;
  logic [15:0] mem_rdata_in;
  logic [15:0] mem_rdata;
  logic mem_we_out, unlocked;

  logic [15:0] pw [8];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  always_comb begin
    if (mem_addr >= PWB && mem_addr < PWB + 16'd8) mem_rdata_in = pw[mem_addr[2:0]];
    else mem_rdata_in = mem_addr ^ 16'hA5A5;
  end

  pwlock i_pwlock (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_fetch(mem_fetch), .pc_secure(pc_secure),
    .mem_addr(mem_addr), .mem_rdata_in(mem_rdata_in), .mem_rdata(mem_rdata),
    .mem_we_out(mem_we_out), .unlocked(unlocked)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_pw(input int kind);
    for (int i = 0; i < 8; i++)
      pw[i] = (kind == 0) ? (16'h1111 * 16'(i + 1)) ^ 16'h0F0F :
              (kind == 1) ? 16'hFFFF : 16'h0000;
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic write_keys(input logic [15:0] flip);
    for (int i = 0; i < 8; i++) reg_write(4'(i), pw[i] ^ ((i == 5) ? flip : 16'h0));
  endtask

  task automatic dummy_reads(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mem_req = 1'b1; mem_we = 1'b0; mem_addr = PWB + 16'(i);
      @(posedge clk); #1;
      mem_req = 1'b0; mem_addr = '0;
    end
  endtask

  task automatic access(input logic [15:0] a, input logic we, input logic f, input logic ps,
                        input logic [15:0] exp_rd, input logic exp_we, input string req);
    @(negedge clk);
    mem_req = 1'b1; mem_we = we; mem_fetch = f; pc_secure = ps; mem_addr = a;
    #1;
    if (we) chk(32'(mem_we_out), 32'(exp_we), req);
    else chk(32'(mem_rdata), 32'(exp_rd), req);
    @(negedge clk);
    mem_req = 1'b0; mem_we = 1'b0; mem_fetch = 1'b0; pc_secure = 1'b0; mem_addr = '0;
  endtask

  task automatic wait_edge_chk(input logic exp, input string req);
    @(posedge clk); #1;
    chk(32'(unlocked), 32'(exp), req);
  endtask

  task automatic t_reset;
    set_pw(0); do_reset;
    #1;
    chk(32'(unlocked), 0, "R1");
    reg_addr = 4'd8; #1;
    chk(32'(reg_rdata), 1, "R1 status");
    reg_addr = '0;
  endtask

  task automatic t_keys_first;
    set_pw(0); do_reset;
    write_keys(16'h0);
    dummy_reads(8);
    chk(32'(unlocked), 0, "R2 not before second edge");
    wait_edge_chk(1'b1, "R2");
  endtask

  task automatic t_reads_first;
    set_pw(0); do_reset;
    dummy_reads(8);
    write_keys(16'h0);
    chk(32'(unlocked), 0, "R3 not before second edge");
    wait_edge_chk(1'b1, "R3");
  endtask

  task automatic t_partial;
    set_pw(0); do_reset;
    write_keys(16'h0);
    dummy_reads(7);
    repeat (3) @(posedge clk);
    #1 chk(32'(unlocked), 0, "R4");
  endtask

  task automatic t_wrong_key;
    set_pw(0); do_reset;
    write_keys(16'h0100);
    dummy_reads(8);
    repeat (3) @(posedge clk);
    #1 chk(32'(unlocked), 0, "R5");
  endtask

  task automatic t_erased;
    set_pw(1); do_reset;
    dummy_reads(8);
    wait_edge_chk(1'b1, "R6");
  endtask

  task automatic t_zero;
    set_pw(2); do_reset;
    write_keys(16'h0);
    dummy_reads(8);
    repeat (4) @(posedge clk);
    #1 chk(32'(unlocked), 0, "R7");
    access(SECA, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, "R7 read still blocked");
  endtask

  task automatic t_relock;
    set_pw(0); do_reset;
    write_keys(16'h0);
    dummy_reads(8);
    wait_edge_chk(1'b1, "R8 precondition");
    reg_write(4'd8, 16'h0001);
    chk(32'(unlocked), 0, "R8 relock");
    reg_addr = 4'd8; #1;
    chk(32'(reg_rdata), 1, "R8 status");
    reg_addr = '0;
    write_keys(16'h0);
    repeat (3) @(posedge clk);
    #1 chk(32'(unlocked), 0, "R8 needs fresh reads");
    dummy_reads(8);
    wait_edge_chk(1'b1, "R8 reunlock");
  endtask

  task automatic t_filter;
    set_pw(0); do_reset;
    access(SECA, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, "R9 read blocked");
    access(SECA, 1'b1, 1'b0, 1'b0, 16'h0000, 1'b0, "R9 write dropped");
    access(SECA, 1'b0, 1'b1, 1'b0, SECA ^ 16'hA5A5, 1'b0, "R10 fetch");
    access(SECA, 1'b0, 1'b0, 1'b1, SECA ^ 16'hA5A5, 1'b0, "R10 secure code read");
    access(SECA, 1'b1, 1'b0, 1'b1, 16'h0, 1'b1, "R10 secure code write");
    access(OUTA, 1'b0, 1'b0, 1'b0, OUTA ^ 16'hA5A5, 1'b0, "R10 outside read");
    access(OUTA, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, "R10 outside write");
    write_keys(16'h0);
    dummy_reads(8);
    wait_edge_chk(1'b1, "R11 precondition");
    access(SECA, 1'b0, 1'b0, 1'b0, SECA ^ 16'hA5A5, 1'b0, "R11 read");
    access(SECA, 1'b1, 1'b0, 1'b0, 16'h0, 1'b1, "R11 write");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    set_pw(0);
    repeat (2) @(posedge clk);
    t_reset;
    t_keys_first;
    t_reads_first;
    t_partial;
    t_wrong_key;
    t_erased;
    t_zero;
    t_relock;
    t_filter;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule